// File: doc/BRIEF.md
# Grid-Locked Unit Vector Generator

This block turns sampled three-phase grid voltages into a pair of unit-length components that track the voltage angle. It is meant as the synchronising source for a shunt compensator's frame transforms. The angle is derived directly from the voltage itself, with no phase-locked loop. Each accepted sample first goes through a first-order smoothing filter on every phase, which damps voltage harmonics. The filtered phases are then projected onto a two-axis stationary frame. The length of that two-axis vector is found with an iterative integer square root. Both axis values are divided by that length in an iterative divider.

The result is two signed fixed-point values with 14 fraction bits. For a balanced sinusoidal grid they trace a unit circle at the grid frequency, whatever that frequency is. When the vector is too short to give a meaningful direction, the outputs keep their previous values. The block takes one sample at a time and shows with a busy flag when it can take the next one.

Top module: `grid_unit_vector`

## Requirements
- R1: After reset, `uv_alpha` and `uv_beta` are 0, and `busy` and `out_valid` are low; all three filter states are 0.
- R2: A sample is accepted on a rising clock edge where `in_valid` is high and `busy` is low. `busy` is high from the next cycle until the result is delivered. Samples presented while `busy` is high have no effect on any later output.
- R3: On each accepted sample, every phase filter state f is updated to f + ((x − f) >>> K), where x is that phase's input, K = `LPF_SHIFT` (default 2), and the shift is arithmetic.
- R4: From the filter states fa, fb, fc, the axis values are computed as a = (26755·(2·fa − fb − fc)) >>> 16 and b = (23170·(fb − fc)) >>> 15, both rounded toward minus infinity. This is a √(2/3)-scaled two-axis projection.
- R5: The vector length is m = floor(√(a² + b²)).
- R6: When m ≥ `MIN_MAG` (default 16), `uv_alpha` = sign(a)·trunc(|a|·16384 / m) and `uv_beta` = sign(b)·trunc(|b|·16384 / m). The value 16384 stands for 1.0, and both outputs are limited to the range −16384 to +16384.
- R7: When m < `MIN_MAG`, both outputs keep their previous values, and `out_valid` still pulses for that sample.
- R8: `out_valid` is a one-cycle pulse per accepted sample, and `busy` falls in the same cycle. The outputs change only in that cycle. The pulse comes RW + 2·NB + 4 clock edges after the accept edge when m ≥ `MIN_MAG` (75 with defaults), and RW + 2 edges when m < `MIN_MAG` (17 with defaults). Here RW = W + 3 and NB = W + 16.
- R9: For a balanced three-phase sinusoid of any frequency, once the filters have settled, `uv_alpha`² + `uv_beta`² is within 2% of 16384².

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| v_a | input | W | Phase A voltage sample, signed |
| v_b | input | W | Phase B voltage sample, signed |
| v_c | input | W | Phase C voltage sample, signed |
| busy | output | 1 | High while a sample is being processed |
| out_valid | output | 1 | One-cycle pulse marking new outputs |
| uv_alpha | output | FRAC+2 | First unit-vector component, signed Q1.14 |
| uv_beta | output | FRAC+2 | Second unit-vector component, signed Q1.14 |

## Verification
Two events can fall in the same cycle: delivery of a result and the offer of the next sample. `busy` drops in the cycle where `out_valid` is high, so a new sample driven at that point is taken on the very next edge. The bench keeps `in_valid` high at all times. While the block is busy it drives corrupted data, and it puts the real sample on the inputs at the first sampling point where `busy` reads low. A scoreboard then compares every output pair and its latency against an integer model of the filter, projection, root and quotient. It would flag any corrupted sample that slipped in, and any result delayed or merged with its neighbour.

// File: rtl/grid_unit_vector.sv
module grid_unit_vector #(
  parameter int W         = 12,
  parameter int LPF_SHIFT = 2,
  parameter int FRAC      = 14,
  parameter int MIN_MAG   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   v_a,
  input  logic signed [W-1:0]   v_b,
  input  logic signed [W-1:0]   v_c,
  output logic                  busy,
  output logic                  out_valid,
  output logic signed [FRAC+1:0] uv_alpha,
  output logic signed [FRAC+1:0] uv_beta
);
  localparam int CW   = W + 2;
  localparam int PW   = CW + 17;
  localparam int SQW  = 2 * CW + 2;
  localparam int RW   = SQW / 2;
  localparam int NB   = CW + FRAC;
  localparam int CNTW = $clog2(NB + 1);
  localparam int ONE_I = 1 << FRAC;
  localparam logic signed [16:0] KA = 17'sd26755;
  localparam logic signed [16:0] KB = 17'sd23170;

  typedef enum logic [2:0] {S_IDLE, S_CALC, S_SQRT, S_CHK, S_DIV, S_FIN} st_t;
  st_t st;

  logic signed [W-1:0] flt [3];
  logic signed [W-1:0] vin [3];
  logic signed [W-1:0] fnx [3];
  logic signed [W:0]   dlt [3];

  assign vin[0] = v_a;
  assign vin[1] = v_b;
  assign vin[2] = v_c;

  always_comb
    for (int i = 0; i < 3; i++) begin
      dlt[i] = $signed({vin[i][W-1], vin[i]}) - $signed({flt[i][W-1], flt[i]});
      fnx[i] = W'($signed({flt[i][W-1], flt[i]}) + (dlt[i] >>> LPF_SHIFT));
    end

  logic signed [CW-1:0] ea, eb, ec, sa, sd, alpha_c, beta_c, alpha_r, beta_r;
  logic signed [2*CW-1:0] a2, b2;
  assign ea = {{2{flt[0][W-1]}}, flt[0]};
  assign eb = {{2{flt[1][W-1]}}, flt[1]};
  assign ec = {{2{flt[2][W-1]}}, flt[2]};
  assign sa = (ea <<< 1) - eb - ec;
  assign sd = eb - ec;
  assign alpha_c = CW'((PW'(sa) * KA) >>> 16);
  assign beta_c  = CW'((PW'(sd) * KB) >>> 15);
  assign a2 = alpha_c * alpha_c;
  assign b2 = beta_c * beta_c;

  logic [SQW-1:0] sq_op, sq_res, sq_one, trial;
  assign trial = sq_res + sq_one;

  logic [RW-1:0] mag_r, dv_rem;
  logic [NB-1:0] dv_num, dv_q;
  logic [RW:0]   rsh, rdiff;
  logic          ge, dv_neg, sel;
  logic [CNTW-1:0] cnt;
  assign rsh   = {dv_rem, dv_num[NB-1]};
  assign rdiff = rsh - {1'b0, mag_r};
  assign ge    = !rdiff[RW];

  logic [CW-1:0] abs_a, abs_b;
  assign abs_a = alpha_r[CW-1] ? CW'(-alpha_r) : alpha_r;
  assign abs_b = beta_r[CW-1]  ? CW'(-beta_r)  : beta_r;

  logic [FRAC+1:0] qs;
  logic signed [FRAC+1:0] qres, q_alpha;
  assign qs   = (dv_q > NB'(ONE_I)) ? (FRAC+2)'(ONE_I) : dv_q[FRAC+1:0];
  assign qres = dv_neg ? -$signed(qs) : $signed(qs);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      for (int i = 0; i < 3; i++) flt[i] <= '0;
      alpha_r <= '0; beta_r <= '0;
      sq_op <= '0; sq_res <= '0; sq_one <= '0;
      mag_r <= '0; dv_rem <= '0; dv_num <= '0; dv_q <= '0;
      dv_neg <= 1'b0; sel <= 1'b0; cnt <= '0;
      q_alpha <= '0; uv_alpha <= '0; uv_beta <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (in_valid) begin
          for (int i = 0; i < 3; i++) flt[i] <= fnx[i];
          st <= S_CALC;
        end
        S_CALC: begin
          alpha_r <= alpha_c;
          beta_r  <= beta_c;
          sq_op   <= SQW'($unsigned(a2)) + SQW'($unsigned(b2));
          sq_res  <= '0;
          sq_one  <= SQW'(1) << (SQW - 2);
          cnt     <= '0;
          st      <= S_SQRT;
        end
        S_SQRT: begin
          if (sq_op >= trial) begin
            sq_op  <= sq_op - trial;
            sq_res <= (sq_res >> 1) + sq_one;
          end else begin
            sq_res <= sq_res >> 1;
          end
          sq_one <= sq_one >> 2;
          cnt    <= cnt + 1'b1;
          if (cnt == CNTW'(RW - 1)) st <= S_CHK;
        end
        S_CHK: begin
          if (sq_res < SQW'(MIN_MAG)) begin
            out_valid <= 1'b1;
            st        <= S_IDLE;
          end else begin
            mag_r  <= sq_res[RW-1:0];
            dv_num <= {abs_a, FRAC'(0)};
            dv_neg <= alpha_r[CW-1];
            dv_rem <= '0;
            dv_q   <= '0;
            sel    <= 1'b0;
            cnt    <= '0;
            st     <= S_DIV;
          end
        end
        S_DIV: begin
          dv_rem <= ge ? rdiff[RW-1:0] : rsh[RW-1:0];
          dv_q   <= {dv_q[NB-2:0], ge};
          dv_num <= dv_num << 1;
          cnt    <= cnt + 1'b1;
          if (cnt == CNTW'(NB - 1)) st <= S_FIN;
        end
        S_FIN: begin
          if (!sel) begin
            q_alpha <= qres;
            dv_num  <= {abs_b, FRAC'(0)};
            dv_neg  <= beta_r[CW-1];
            dv_rem  <= '0;
            dv_q    <= '0;
            sel     <= 1'b1;
            cnt     <= '0;
            st      <= S_DIV;
          end else begin
            uv_alpha  <= q_alpha;
            uv_beta   <= qres;
            out_valid <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/grid_unit_vector_chk.sv
module grid_unit_vector_chk #(
  parameter int FRAC = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   busy,
  input logic                   out_valid,
  input logic signed [FRAC+1:0] uv_alpha,
  input logic signed [FRAC+1:0] uv_beta
);
  localparam logic signed [FRAC+1:0] ONE = (FRAC+2)'(1 << FRAC);

  p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);

  p_out_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (uv_alpha <= ONE && uv_alpha >= -ONE && uv_beta <= ONE && uv_beta >= -ONE));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_valid_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!busy && $past(busy)));

  p_outputs_steady_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(uv_alpha) && $stable(uv_beta)));
endmodule

bind grid_unit_vector grid_unit_vector_chk #(.FRAC(FRAC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .uv_alpha(uv_alpha), .uv_beta(uv_beta)
);

// File: tb/tb_grid_unit_vector.sv
`timescale 1ns/1ps
module tb_grid_unit_vector;
  localparam int W = 12, K = 2, FRAC = 14, MIN_MAG = 16;
  localparam int RW = W + 3, NB = W + 16;
  localparam int LAT_FULL = RW + 2*NB + 4;
  localparam int LAT_HOLD = RW + 2;
  localparam int ONE = 1 << FRAC;

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [W-1:0] v_a = 0, v_b = 0, v_c = 0;
  logic busy, out_valid;
  logic signed [FRAC+1:0] uv_alpha, uv_beta;

  grid_unit_vector #(.W(W), .LPF_SHIFT(K), .FRAC(FRAC), .MIN_MAG(MIN_MAG)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .v_a(v_a), .v_b(v_b), .v_c(v_c),
    .busy(busy), .out_valid(out_valid), .uv_alpha(uv_alpha), .uv_beta(uv_beta));

  always #2 clk = ~clk;

  typedef struct { int ea; int eb; int lat; bit steady; int cyc; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  int fa = 0, fb = 0, fc = 0, last_a = 0, last_b = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int isqrt(input int s);
    int r = 0;
    for (int bitv = 1 << 15; bitv > 0; bitv >>= 1)
      if ((r + bitv) * (r + bitv) <= s) r += bitv;
    return r;
  endfunction

  function automatic int udiv(input int v, input int m);
    int av = (v < 0) ? -v : v;
    int qq = (av * ONE) / m;
    if (qq > ONE) qq = ONE;
    return (v < 0) ? -qq : qq;
  endfunction

  task automatic send(input int xa, input int xb, input int xc, input bit steady);
    exp_t e;
    int a, b, m;
    while (busy) @(negedge clk);
    fa = fa + ((xa - fa) >>> K);
    fb = fb + ((xb - fb) >>> K);
    fc = fc + ((xc - fc) >>> K);
    a = (26755 * (2*fa - fb - fc)) >>> 16;
    b = (23170 * (fb - fc)) >>> 15;
    m = isqrt(a*a + b*b);
    if (m >= MIN_MAG) begin
      last_a = udiv(a, m);
      last_b = udiv(b, m);
      e.lat = LAT_FULL;
    end else begin
      e.lat = LAT_HOLD;
    end
    e.ea = last_a; e.eb = last_b; e.steady = steady && (m >= MIN_MAG);
    v_a = W'(xa); v_b = W'(xb); v_c = W'(xc);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    e.cyc = cyc;
    q.push_back(e);
    v_a = ~v_a; v_b = W'(xc + 700); v_c = W'(-xa);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        int pw;
        e = q.pop_front();
        check(uv_alpha == e.ea, "R2 R3 R4 R5 R6 R7 uv_alpha", uv_alpha, e.ea);
        check(uv_beta == e.eb, "R2 R3 R4 R5 R6 R7 uv_beta", uv_beta, e.eb);
        check(busy == 0, "R8 busy low with out_valid", busy, 0);
        check(cyc - e.cyc == e.lat, "R8 latency", cyc - e.cyc, e.lat);
        if (e.steady) begin
          pw = int'(uv_alpha) * int'(uv_alpha) + int'(uv_beta) * int'(uv_beta);
          check(pw > (ONE*ONE/50)*49 && pw < (ONE*ONE/50)*51, "R9 unit amplitude", pw, ONE*ONE);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    real th;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(uv_alpha == 0, "R1 reset uv_alpha", uv_alpha, 0);
    check(uv_beta == 0, "R1 reset uv_beta", uv_beta, 0);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(out_valid == 0, "R1 reset out_valid", out_valid, 0);

    for (int i = 0; i < 3; i++) send(0, 0, 0, 0);             // R7 zero vector hold
    for (int i = 0; i < 14; i++) send(1000, -500, -500, 0);   // R6 pure positive axis
    for (int i = 0; i < 14; i++) send(-2000, 1000, 1000, 0);  // R6 negative axis
    for (int i = 0; i < 10; i++) send(0, 1500, -1500, 0);     // second axis only
    for (int i = 0; i < 6; i++) send(2047, -2048, -2048, 0);  // input extremes
    for (int i = 0; i < 60; i++) begin                        // R9 first frequency
      th = 2.0 * 3.14159265358979 * i / 48.0;
      send($rtoi(1800.0*$sin(th)), $rtoi(1800.0*$sin(th - 2.0943951)),
           $rtoi(1800.0*$sin(th + 2.0943951)), i >= 16);
    end
    for (int i = 0; i < 50; i++) begin                        // R9 second frequency
      th = 2.0 * 3.14159265358979 * i / 20.0;
      send($rtoi(1500.0*$sin(th)), $rtoi(1500.0*$sin(th - 2.0943951)),
           $rtoi(1500.0*$sin(th + 2.0943951)), i >= 16);
    end
    for (int i = 0; i < 30; i++) send(0, 0, 0, 0);            // R7 decay below threshold
    for (int i = 0; i < 4; i++) send(3, -3, 1, 0);            // R7 tiny vector keeps outputs
    while (busy) @(negedge clk);
    in_valid = 0;
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R8 every accepted sample answered", q.size(), 0);
    check(out_valid == 0 && busy == 0, "R2 idle after stream", busy, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule